// File: doc/BRIEF.md
# ADC Conversion Command Sequencer

This block is the control core of a multi-channel analog-to-digital converter peripheral. Software fills a sequence table of channel entries over a simple word-addressed register bus and then writes a command word. The sequencer decodes the command and walks the table. For each entry it holds a sampling phase of a programmable length, then starts the external converter on the selected channel and resolution. It collects the returned result and pushes it, left-justified to 12 bits, into a result FIFO port.

There are two kinds of conversion run. A single-shot run converts a fixed number of samples and then raises a command-complete pulse. A continuous run repeats batches of that size, raises a batch-complete pulse after each batch, and keeps going until a stop command arrives. Three calibration commands clear, load or run the calibration, and the resulting 6-bit value can be read back over the bus. The converter, the FIFO storage and any interrupt registers sit outside the block.

Top module: `adc_cmd_sequencer`

## Requirements
- R1: The command opcode is in bits [2:0] of a write to the command address (word 8). The codes are: 0 single run, 1 continuous run, 2 clear calibration, 3 run calibration, 4 load calibration, 5 stop. Codes 6 and 7 produce no conversion, no event and no calibration change.
- R2: Table entry i (0..31) is stored in bus word i/4 (addresses 0..7), in byte bits [8*(i%4)+7 : 8*(i%4)]. A read of a table word returns the written value one clock after the address is presented.
- R3: Bits [4:0] of an entry appear on `conv_chan` together with `conv_start`, and bits [6:5] are ignored. Bit 7 marks the last entry: after that entry the walk resumes at entry 0, and it also resumes at entry 0 after entry 31. Every accepted run starts at entry 0.
- R4: In the command word, bits [10:6] hold the sample count minus one and bit 3 is the event enable. A single run pushes count+1 samples. It then pulses `cmd_done` for one clock if the enable is 1, and pulses nothing if it is 0.
- R5: A continuous run pulses `batch_done` (when enabled) in the clock of the sample push that completes each group of count+1 samples, and the table walk carries on across batches. A stop command ends the run at once: no further `conv_start` occurs, and a result returned after the stop is not pushed. `cmd_done` and `batch_done` never pulse together.
- R6: The window field is bits [18:11] and holds W. `conv_start` is a one-clock pulse that rises exactly W clocks after the clock edge that accepts the command, and exactly W clocks after each sample push.
- R7: The resolution code is in bits [5:4] and r selects 6+2r bits. A run command whose window is below 8+2r is rejected and causes no activity.
- R8: `conv_res` carries r during a run. The converter returns its result right-justified in `conv_data`; bits above the selected width are ignored. The result is pushed shifted left by 6-2r bits, with zero low bits.
- R9: Clear calibration sets the calibration value to 0. Load calibration sets it from command bits [24:19]. Run calibration pulses `cal_start` and captures `cal_result` when `cal_done` arrives. Each of the three ends with a `cmd_done` pulse when enabled, and the value reads back at address 9 in bits [5:0].
- R10: While a run or a calibration is active, every command other than stop is ignored.
- R11: After reset all event and strobe outputs are low and the calibration value reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address: 0..7 table, 8 command, 9 calibration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| conv_start | output | 1 | Converter start pulse |
| conv_chan | output | 5 | Channel to convert |
| conv_res | output | 2 | Resolution code for the converter |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | 12 | Converter result, right-justified |
| cal_start | output | 1 | Calibration start pulse |
| cal_done | input | 1 | Calibration finished |
| cal_result | input | 6 | Calibration value from the converter |
| fifo_push | output | 1 | Result FIFO write strobe |
| fifo_data | output | 12 | Left-justified sample |
| cmd_done | output | 1 | Command-complete pulse |
| batch_done | output | 1 | Continuous batch-complete pulse |

## Verification
The table is loaded with a five-entry list that ends in a flagged entry and has entries with the ignored bits set. A single run longer than the list shows whether the walk returns to entry 0 at the flag and whether bits [6:5] leak into the channel. Each resolution code is run with converter data that has bits set above the selected width, which separates correct masking and shifting from a plain copy. A continuous run is checked for batch pulses on the third and sixth pushes and for a walk that carries across batches, then stopped mid-flight. Windows exactly at the minimum and one clock below it are compared, and commands written during a busy run are shown to leave both the sample count and the calibration readback unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SMP_W  = 12;
  localparam int CH_W   = 5;
  localparam int WIN_W  = 8;
  localparam int CNT_W  = 5;
  localparam int CAL_W  = 6;
  localparam int CMD_W  = 3 + 1 + 2 + CNT_W + WIN_W + CAL_W;

  typedef enum logic [2:0] {
    OP_SINGLE   = 3'd0,
    OP_CONT     = 3'd1,
    OP_CAL_CLR  = 3'd2,
    OP_CAL_RUN  = 3'd3,
    OP_CAL_LOAD = 3'd4,
    OP_STOP     = 3'd5
  } op_e;

  typedef struct packed {
    logic [CAL_W-1:0] cal;
    logic [WIN_W-1:0] win;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       res;
    logic             ie;
    logic [2:0]       op;
  } cmd_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SAMPLE, ST_CONV, ST_CAL} state_e;
endpackage

// File: rtl/adc_seq_table.sv
module adc_seq_table #(
  parameter int ENTRIES = 32,
  localparam int WORDS  = ENTRIES / 4,
  localparam int WI_W   = $clog2(WORDS),
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [WI_W-1:0]  waddr,
  input  logic [31:0]      wdata,
  input  logic [WI_W-1:0]  bus_raddr,
  output logic [31:0]      bus_word,
  input  logic [IDX_W-1:0] idx,
  output logic [4:0]       entry_ch,
  output logic             entry_last
);
  logic [31:0] mem [WORDS];
  logic [31:0] walk_word;
  logic [7:0]  lane [4];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign bus_word  = mem[bus_raddr];
  assign walk_word = mem[idx[IDX_W-1:2]];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign lane[g] = walk_word[8*g +: 8];
  end

  assign entry_ch   = lane[idx[1:0]][4:0];
  assign entry_last = lane[idx[1:0]][7];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  cmd_t             cmd,
  input  logic [CH_W-1:0]  entry_ch,
  input  logic             entry_last,
  input  logic             conv_done,
  input  logic [SMP_W-1:0] conv_data,
  input  logic             cal_done,
  input  logic [CAL_W-1:0] cal_result,
  output logic [IDX_W-1:0] idx,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic [1:0]       conv_res,
  output logic             cal_start,
  output logic [CAL_W-1:0] cal_val,
  output logic             fifo_push,
  output logic [SMP_W-1:0] fifo_data,
  output logic             cmd_done,
  output logic             batch_done
);
  state_e           state;
  logic [WIN_W-1:0] win_cnt, win_q;
  logic [CNT_W-1:0] left, cnt_q;
  logic             ie_q, cont_q;
  logic [WIN_W:0]   win_min;
  logic             win_ok;
  logic [3:0]       shamt;
  logic [SMP_W-1:0] res_mask, justified;

  assign win_min   = (WIN_W+1)'(8) + (WIN_W+1)'({cmd.res, 1'b0});
  assign win_ok    = {1'b0, cmd.win} >= win_min;
  assign shamt     = 4'd6 - {1'b0, conv_res, 1'b0};
  assign res_mask  = {SMP_W{1'b1}} >> shamt;
  assign justified = (conv_data & res_mask) << shamt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;  win_cnt <= '0;  win_q <= '0;
      left <= '0;  cnt_q <= '0;  ie_q <= 1'b0;  cont_q <= 1'b0;
      idx <= '0;  conv_start <= 1'b0;  conv_chan <= '0;  conv_res <= '0;
      cal_start <= 1'b0;  cal_val <= '0;  fifo_push <= 1'b0;
      fifo_data <= '0;  cmd_done <= 1'b0;  batch_done <= 1'b0;
    end else begin
      conv_start <= 1'b0;  cal_start <= 1'b0;  fifo_push <= 1'b0;
      cmd_done <= 1'b0;  batch_done <= 1'b0;
      if (cmd_wr && cmd.op == OP_STOP) begin
        if (state == ST_SAMPLE || state == ST_CONV) state <= ST_IDLE;
      end else begin
        unique case (state)
          ST_IDLE: if (cmd_wr) begin
            unique case (cmd.op)
              OP_SINGLE, OP_CONT: if (win_ok) begin
                state <= ST_SAMPLE;  win_cnt <= cmd.win;  win_q <= cmd.win;
                left <= cmd.cnt;  cnt_q <= cmd.cnt;  ie_q <= cmd.ie;
                cont_q <= (cmd.op == OP_CONT);  conv_res <= cmd.res;
                idx <= '0;
              end
              OP_CAL_CLR:  begin cal_val <= '0;      cmd_done <= cmd.ie; end
              OP_CAL_LOAD: begin cal_val <= cmd.cal; cmd_done <= cmd.ie; end
              OP_CAL_RUN:  begin cal_start <= 1'b1;  ie_q <= cmd.ie;  state <= ST_CAL; end
              default: ;
            endcase
          end
          ST_SAMPLE: begin
            if (win_cnt == WIN_W'(1)) begin
              conv_start <= 1'b1;  conv_chan <= entry_ch;  state <= ST_CONV;
            end else begin
              win_cnt <= win_cnt - 1'b1;
            end
          end
          ST_CONV: if (conv_done) begin
            fifo_push <= 1'b1;  fifo_data <= justified;  win_cnt <= win_q;
            idx <= (entry_last || idx == IDX_W'(ENTRIES-1)) ? '0 : idx + 1'b1;
            if (left == '0) begin
              if (cont_q) begin
                batch_done <= ie_q;  left <= cnt_q;  state <= ST_SAMPLE;
              end else begin
                cmd_done <= ie_q;  state <= ST_IDLE;
              end
            end else begin
              left <= left - 1'b1;  state <= ST_SAMPLE;
            end
          end
          ST_CAL: if (cal_done) begin
            cal_val <= cal_result;  cmd_done <= ie_q;  state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_cmd_sequencer.sv
module adc_cmd_sequencer
  import adc_seq_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int AW      = 4,
  localparam int WORDS  = ENTRIES / 4,
  localparam int WI_W   = $clog2(WORDS),
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             conv_start,
  output logic [CH_W-1:0]  conv_chan,
  output logic [1:0]       conv_res,
  input  logic             conv_done,
  input  logic [SMP_W-1:0] conv_data,
  output logic             cal_start,
  input  logic             cal_done,
  input  logic [CAL_W-1:0] cal_result,
  output logic             fifo_push,
  output logic [SMP_W-1:0] fifo_data,
  output logic             cmd_done,
  output logic             batch_done
);
  localparam logic [AW-1:0] CMD_ADDR = AW'(WORDS);
  localparam logic [AW-1:0] CAL_ADDR = AW'(WORDS + 1);

  logic             tbl_we, cmd_wr;
  logic [31:0]      tbl_word;
  logic [IDX_W-1:0] idx;
  logic [CH_W-1:0]  entry_ch;
  logic             entry_last;
  logic [CAL_W-1:0] cal_val;

  assign tbl_we = bus_we && (bus_addr < AW'(WORDS));
  assign cmd_wr = bus_we && (bus_addr == CMD_ADDR);

  adc_seq_table #(.ENTRIES(ENTRIES)) i_table (
    .clk(clk), .we(tbl_we), .waddr(bus_addr[WI_W-1:0]), .wdata(bus_wdata),
    .bus_raddr(bus_addr[WI_W-1:0]), .bus_word(tbl_word),
    .idx(idx), .entry_ch(entry_ch), .entry_last(entry_last)
  );

  adc_seq_ctrl #(.ENTRIES(ENTRIES)) i_ctrl (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd(cmd_t'(bus_wdata[CMD_W-1:0])),
    .entry_ch(entry_ch), .entry_last(entry_last),
    .conv_done(conv_done), .conv_data(conv_data),
    .cal_done(cal_done), .cal_result(cal_result),
    .idx(idx), .conv_start(conv_start), .conv_chan(conv_chan),
    .conv_res(conv_res), .cal_start(cal_start), .cal_val(cal_val),
    .fifo_push(fifo_push), .fifo_data(fifo_data),
    .cmd_done(cmd_done), .batch_done(batch_done)
  );

  always_ff @(posedge clk) begin
    if (rst)                         bus_rdata <= '0;
    else if (bus_addr < AW'(WORDS))  bus_rdata <= tbl_word;
    else if (bus_addr == CAL_ADDR)   bus_rdata <= 32'(cal_val);
    else                             bus_rdata <= '0;
  end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic        clk,
  input logic        rst,
  input logic        conv_start,
  input logic [4:0]  conv_chan,
  input logic [1:0]  conv_res,
  input logic        cal_start,
  input logic        fifo_push,
  input logic [11:0] fifo_data,
  input logic        cmd_done,
  input logic        batch_done
);
  logic        waiting;
  logic [11:0] low_mask;

  assign low_mask = (12'h001 << (4'd6 - {1'b0, conv_res, 1'b0})) - 12'h001;

  always_ff @(posedge clk) begin
    if (rst)             waiting <= 1'b0;
    else if (conv_start) waiting <= 1'b1;
    else if (fifo_push)  waiting <= 1'b0;
  end

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  assert_push_gap_R6: assert property (@(posedge clk) disable iff (rst)
    fifo_push |=> !conv_start);
  assert_low_zero_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_push |-> ((fifo_data & low_mask) == 12'h000));
  assert_events_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(cmd_done && batch_done));
  assert_chan_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (waiting && !conv_start) |-> $stable(conv_chan));
  assert_cal_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cal_start |=> !cal_start);
endmodule

bind adc_cmd_sequencer adc_seq_checker i_checker (
  .clk(clk), .rst(rst), .conv_start(conv_start), .conv_chan(conv_chan),
  .conv_res(conv_res), .cal_start(cal_start), .fifo_push(fifo_push),
  .fifo_data(fifo_data), .cmd_done(cmd_done), .batch_done(batch_done)
);

// File: tb/test_adc_cmd_sequencer.sv
module test_adc_cmd_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        conv_start, conv_done = 1'b0;
  logic [4:0]  conv_chan;
  logic [1:0]  conv_res;
  logic [11:0] conv_data = '0, fifo_data;
  logic        cal_start, cal_done = 1'b0;
  logic [5:0]  cal_result = '0;
  logic        fifo_push, cmd_done, batch_done;

  adc_cmd_sequencer i_adc_cmd_sequencer (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_push = 0, n_done = 0, n_batch = 0, n_cal = 0;
  int start_cyc [256];  int push_cyc [256];
  logic [4:0]  chan_log [256];
  logic [11:0] data_log [256], exp_log [256];
  int batch_at [16];
  logic [11:0] last_exp = '0;
  int resp_k = 0, cmd_cyc = 0;
  logic [4:0] tb_ch [32];
  logic       tb_end [32];

  always @(posedge clk) cyc <= cyc + 1;

  // observation at the falling edge
  initial forever begin
    @(negedge clk);
    if (conv_start) begin start_cyc[n_start % 256] = cyc; chan_log[n_start % 256] = conv_chan; n_start++; end
    if (fifo_push) begin
      push_cyc[n_push % 256] = cyc; data_log[n_push % 256] = fifo_data;
      exp_log[n_push % 256] = last_exp; n_push++;
    end
    if (batch_done) begin batch_at[n_batch % 16] = n_push; n_batch++; end
    if (cmd_done) n_done++;
    if (cal_start) n_cal++;
  end

  // converter responder
  initial forever begin
    @(negedge clk);
    if (conv_start) begin
      logic [11:0] raw;
      logic [3:0]  sh;
      raw = 12'(conv_chan * 13 + resp_k * 7 + 5) | 12'hC00;
      resp_k++;
      sh = 4'd6 - {1'b0, conv_res, 1'b0};
      repeat (2) @(negedge clk);
      conv_done = 1'b1; conv_data = raw;
      last_exp = ((raw & (12'hFFF >> sh)) << sh);
      @(negedge clk);
      conv_done = 1'b0;
    end
  end

  // calibration responder
  initial forever begin
    @(negedge clk);
    if (cal_start) begin
      repeat (3) @(negedge clk);
      cal_done = 1'b1; cal_result = 6'h2C;
      @(negedge clk);
      cal_done = 1'b0;
    end
  end

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, act=hung exp=finished");
    report();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input int op, input bit ie, input int res,
                                         input int cnt, input int win, input int cal);
    return {7'd0, 6'(cal), 8'(win), 5'(cnt), 2'(res), ie, 3'(op)};
  endfunction

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'(addr); bus_wdata = data;
    @(negedge clk);
    cmd_cyc = cyc;
    bus_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    bus_addr = 4'(addr);
    @(negedge clk);
    data = bus_rdata;
  endtask

  task automatic wait_push(input int target);
    for (int i = 0; i < 5000 && n_push < target; i++) @(negedge clk);
  endtask

  function automatic int next_p(input int p);
    return (tb_end[p] || p == 31) ? 0 : p + 1;
  endfunction

  task automatic load_table;
    logic [7:0] e [32];
    for (int i = 0; i < 32; i++) begin e[i] = 8'h00; tb_ch[i] = 5'd0; tb_end[i] = 1'b0; end
    e[0] = 8'h03; e[1] = 8'h67; e[2] = 8'h0C; e[3] = 8'h5F; e[4] = 8'h81;
    for (int i = 0; i < 32; i++) begin tb_ch[i] = e[i][4:0]; tb_end[i] = e[i][7]; end
    for (int w = 0; w < 8; w++) wr(w, {e[4*w+3], e[4*w+2], e[4*w+1], e[4*w]});
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(!conv_start && !fifo_push && !cmd_done && !batch_done && !cal_start, "R11 outputs", 0, 0);
    rd(9, v);
    chk(v == 0, "R11 cal value", v, 0);
  endtask

  task automatic t_table;
    logic [31:0] v;
    wr(5, 32'hA1B2C3D4);
    rd(5, v);
    chk(v == 32'hA1B2C3D4, "R2 word readback", v, 32'hA1B2C3D4);
    load_table();
    rd(1, v);
    chk(v == 32'h00000081, "R2 entry 4 lane", v, 32'h81);
  endtask

  task automatic t_single;
    int b = n_push, s = n_start, d = n_done, p = 0;
    wr(8, mk_cmd(0, 1, 3, 6, 14, 0));
    wait_push(b + 7);
    repeat (20) @(negedge clk);
    chk(n_push - b == 7, "R4 sample count", n_push - b, 7);
    chk(n_done - d == 1, "R4 cmd_done", n_done - d, 1);
    chk(start_cyc[s] - cmd_cyc == 14, "R6 first window", start_cyc[s] - cmd_cyc, 14);
    chk(start_cyc[s+1] - push_cyc[b] == 14, "R6 window after push", start_cyc[s+1] - push_cyc[b], 14);
    for (int i = 0; i < 7; i++) begin
      chk(chan_log[s+i] == tb_ch[p], "R3 channel walk", chan_log[s+i], tb_ch[p]);
      p = next_p(p);
    end
    for (int i = 0; i < 7; i++)
      chk(data_log[b+i] == exp_log[b+i], "R8 12-bit data", data_log[b+i], exp_log[b+i]);
  endtask

  task automatic t_no_ie;
    int b = n_push, d = n_done;
    wr(8, mk_cmd(0, 0, 1, 0, 12, 0));
    wait_push(b + 1);
    repeat (20) @(negedge clk);
    chk(n_push - b == 1, "R4 count 0 gives one sample", n_push - b, 1);
    chk(n_done == d, "R4 no event with enable clear", n_done - d, 0);
  endtask

  task automatic t_reject;
    int s = n_start, d = n_done;
    wr(8, mk_cmd(0, 1, 3, 0, 13, 0));
    repeat (40) @(negedge clk);
    chk(n_start == s, "R7 window 13 at 12 bits rejected", n_start - s, 0);
    wr(8, mk_cmd(1, 1, 0, 0, 7, 0));
    repeat (40) @(negedge clk);
    chk(n_start == s && n_done == d, "R7 window 7 at 6 bits rejected", n_start - s, 0);
  endtask

  task automatic t_resolution;
    for (int r = 0; r < 4; r++) begin
      int b = n_push, s = n_start;
      wr(8, mk_cmd(0, 1, r, 0, 8 + 2*r, 0));
      wait_push(b + 1);
      repeat (4) @(negedge clk);
      chk(start_cyc[s] - cmd_cyc == 8 + 2*r, "R6 minimum window", start_cyc[s] - cmd_cyc, 8 + 2*r);
      chk(conv_res == 2'(r), "R8 resolution code", conv_res, r);
      chk(data_log[b] == exp_log[b], "R8 justified sample", data_log[b], exp_log[b]);
    end
  endtask

  task automatic t_continuous;
    int b = n_push, s = n_start, bb = n_batch, d = n_done, p = 0, after;
    wr(8, mk_cmd(1, 1, 2, 2, 12, 0));
    for (int i = 0; i < 5000 && n_batch < bb + 2; i++) @(negedge clk);
    repeat (15) @(negedge clk);
    wr(8, mk_cmd(5, 0, 0, 0, 0, 0));
    after = n_push;
    repeat (5) @(negedge clk);
    after = n_push;
    s = s;
    repeat (100) @(negedge clk);
    chk(batch_at[bb % 16] - b == 3, "R5 first batch at third push", batch_at[bb % 16] - b, 3);
    chk(batch_at[(bb+1) % 16] - b == 6, "R5 second batch at sixth push", batch_at[(bb+1) % 16] - b, 6);
    chk(n_push == after, "R5 nothing pushed after stop", n_push - after, 0);
    chk(n_done == d, "R5 no cmd_done in continuous", n_done - d, 0);
    for (int i = 0; i < 6; i++) begin
      chk(chan_log[s+i] == tb_ch[p], "R5 walk carries across batches", chan_log[s+i], tb_ch[p]);
      p = next_p(p);
    end
  endtask

  task automatic t_busy;
    int b = n_push, d = n_done, c = n_cal;
    logic [31:0] v;
    wr(8, mk_cmd(4, 1, 0, 0, 0, 9));
    rd(9, v);
    chk(v == 9, "R9 load value", v, 9);
    wr(8, mk_cmd(0, 1, 0, 3, 20, 0));
    repeat (5) @(negedge clk);
    wr(8, mk_cmd(4, 1, 0, 0, 0, 42));
    wr(8, mk_cmd(0, 1, 0, 9, 20, 0));
    wr(8, mk_cmd(3, 1, 0, 0, 0, 0));
    wait_push(b + 4);
    repeat (60) @(negedge clk);
    chk(n_push - b == 4, "R10 second start ignored", n_push - b, 4);
    chk(n_done - d == 2, "R10 single done only", n_done - d, 2);
    chk(n_cal == c, "R10 calibration start ignored", n_cal - c, 0);
    rd(9, v);
    chk(v == 9, "R10 load ignored while busy", v, 9);
  endtask

  task automatic t_cal;
    int d = n_done, c = n_cal, s = n_start;
    logic [31:0] v;
    wr(8, mk_cmd(4, 1, 0, 0, 0, 6'h15));
    repeat (3) @(negedge clk);
    rd(9, v);
    chk(v == 32'h15, "R9 load calibration", v, 32'h15);
    wr(8, mk_cmd(2, 1, 0, 0, 0, 0));
    repeat (3) @(negedge clk);
    rd(9, v);
    chk(v == 0, "R9 clear calibration", v, 0);
    wr(8, mk_cmd(3, 1, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(9, v);
    chk(v == 32'h2C, "R9 run calibration result", v, 32'h2C);
    chk(n_cal - c == 1, "R9 cal_start pulse", n_cal - c, 1);
    chk(n_done - d == 3, "R9 three completions", n_done - d, 3);
    wr(8, mk_cmd(6, 1, 0, 0, 20, 6'h3F));
    wr(8, mk_cmd(7, 1, 0, 0, 20, 6'h3F));
    repeat (40) @(negedge clk);
    rd(9, v);
    chk(v == 32'h2C && n_start == s && n_done - d == 3, "R1 unused opcodes ignored", v, 32'h2C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_table();
    t_single();
    t_no_ie();
    t_reject();
    t_resolution();
    t_continuous();
    t_busy();
    t_cal();
    report();
  end
endmodule